// File: doc/BRIEF.md
# Nested Interrupt Level Controller

This block sits between a set of peripheral interrupt lines and a CPU core and decides when a request may break into the running code. Every source has a programmable two-bit urgency. A smaller number is more urgent, and the value 3 means the source is never serviced. The block also keeps the CPU's current-level field and global interrupt enable. A request is offered to the CPU only when interrupts are enabled and the request's urgency beats the current level.

An offered request is presented as a held grant with a vector index. When the CPU acknowledges it, three things happen on that clock edge: the block pushes the current status onto a small save stack, raises the current level to that of the accepted source, and pulses a save strobe for the program counter logic. A return strobe pops the stack and restores the enable and level that were live before entry. This lets a more urgent source nest inside a less urgent handler, and the interrupted level resumes afterwards. Software sets the per-source levels and the status through one register write port.

Top module: `irq_level_ctrl`

## Requirements
- R1: After reset the grant is low, the current level is 3, the global enable is 0 and every source level field holds 3, so no request is granted even once the enable is set with the current level at 3.
- R2: A write to address a (0 to 3) loads the level of source 4a+k from data bits [2k+1:2k]; a write to address 4 loads the current level from bits [1:0] and the global enable from bit 2; a stored source field of 0 acts as level 1.
- R3: A request is granted only while the global enable is 1 and its level is numerically below the current level; a source at level 3 is never granted.
- R4: Among eligible requests the smallest level wins, and among equal levels the lowest source index wins.
- R5: The grant rises on the clock edge after an eligible request is first sampled, stays high with an unchanged vector index until acknowledged, ignores newer requests meanwhile, and falls on the edge that takes the acknowledge.
- R6: On the acknowledge edge the current level takes the granted source's level, the global enable is unchanged, and the save strobe is high during the acknowledge cycle.
- R7: A more urgent request is granted inside a running handler, and each return restores the enable and level saved at the matching entry, in last-in first-out order.
- R8: A return while the save stack is empty leaves the enable and level unchanged.
- R9: With the current level written to 0, no request is granted.
- R10: While the save stack holds its full depth (4 entries by default), no request is granted.
- R11: On one edge, an acknowledge takes precedence over a status write and a return. A return that pops the stack takes precedence over a status write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| irqReq | input | NUM_SRC | Level-sensitive peripheral request lines |
| regWrEn | input | 1 | Register write strobe |
| regAddr | input | AW | Register address: 0..3 source levels, 4 status |
| regWrData | input | 8 | Register write data |
| intAck | input | 1 | CPU acknowledge of the held grant |
| retStrobe | input | 1 | Return-from-interrupt strobe |
| intReq | output | 1 | Held grant to the CPU |
| vecIdx | output | VW | Index of the granted source |
| pcSave | output | 1 | Save strobe for the program counter during acknowledge |
| statusLevel | output | 2 | Current interrupt level |
| statusIe | output | 1 | Global interrupt enable |

## Verification
The entry checks assume two things about the inputs. Software does not rewrite the status register while a grant is waiting for its acknowledge. The CPU acknowledges only while the grant is high. Together these make every entry strictly raise urgency and leave the enable untouched. The stimulus keeps to this: status writes happen only when no grant is pending, except in the one precedence test, where the write shares the acknowledge edge. Every source is lowered before the return that would otherwise make it eligible again, so each grant that does appear is one the scoreboard predicted.

// File: rtl/ilc_pkg.sv
package ilc_pkg;

  localparam logic [1:0] LVL_NEVER = 2'd3;
  localparam int STAT_IE_BIT = 2;

  typedef struct packed {
    logic       ie;
    logic [1:0] lvl;
  } status_t;

  typedef struct packed {
    logic capture;   // latch arbitration winner into the grant
    logic enter;     // acknowledge: push status, load new level
    logic leave;     // return: pop status
    logic wrStatus;  // software write of status accepted
  } ctrl_t;

endpackage

// File: rtl/ilc_datapath.sv
module ilc_datapath
  import ilc_pkg::*;
#(
  parameter int NUM_SRC = 16,
  parameter int DEPTH   = 4,
  parameter int DW      = 8,
  parameter int AW      = 3,
  parameter int VW      = 4
) (
  input  logic               clk,
  input  logic               rstN,
  input  ctrl_t              ctrl,
  input  logic [NUM_SRC-1:0] irqReq,
  input  logic               regWrEn,
  input  logic [AW-1:0]      regAddr,
  input  logic [DW-1:0]      regWrData,
  output logic               anyEligible,
  output logic               stackFull,
  output logic               stackEmpty,
  output logic [VW-1:0]      vecIdx,
  output status_t            status
);

  localparam int FIELDS_PER_REG = DW / 2;
  localparam int CNTW = $clog2(DEPTH + 1);
  localparam int IDXW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [1:0]         lvlField [NUM_SRC];
  logic [1:0]         effLvl   [NUM_SRC];
  logic [NUM_SRC-1:0] eligible;

  // Per-source level fields and eligibility
  for (genvar s = 0; s < NUM_SRC; s++) begin : g_src
    localparam int REG_IDX = s / FIELDS_PER_REG;
    localparam int SLOT    = s % FIELDS_PER_REG;

    always_ff @(posedge clk) begin
      if (!rstN)
        lvlField[s] <= LVL_NEVER;
      else if (regWrEn && (regAddr == AW'(REG_IDX)))
        lvlField[s] <= regWrData[2*SLOT +: 2];
    end

    assign effLvl[s]   = (lvlField[s] == 2'd0) ? 2'd1 : lvlField[s];
    assign eligible[s] = irqReq[s] && status.ie &&
                         (effLvl[s] != LVL_NEVER) && (effLvl[s] < status.lvl);
  end

  // Arbitration: smallest level first, lowest index on ties
  logic          found;
  logic [1:0]    bestLvl;
  logic [VW-1:0] bestIdx;

  always_comb begin
    found   = 1'b0;
    bestLvl = LVL_NEVER;
    bestIdx = '0;
    for (int i = 0; i < NUM_SRC; i++) begin
      if (eligible[i] && (!found || (effLvl[i] < bestLvl))) begin
        found   = 1'b1;
        bestLvl = effLvl[i];
        bestIdx = VW'(i);
      end
    end
  end

  assign anyEligible = found;

  // Held grant contents
  logic [1:0] lvlReg;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      vecIdx <= '0;
      lvlReg <= LVL_NEVER;
    end else if (ctrl.capture) begin
      vecIdx <= bestIdx;
      lvlReg <= bestLvl;
    end
  end

  // Save stack
  status_t          stackMem [DEPTH];
  logic [CNTW-1:0]  stackPtr;
  logic [IDXW-1:0]  pushIdx;
  logic [IDXW-1:0]  popIdx;

  assign pushIdx    = IDXW'(stackPtr);
  assign popIdx     = IDXW'(stackPtr - CNTW'(1));
  assign stackFull  = (stackPtr == CNTW'(DEPTH));
  assign stackEmpty = (stackPtr == '0);

  always_ff @(posedge clk) begin
    if (ctrl.enter)
      stackMem[pushIdx] <= status;
  end

  always_ff @(posedge clk) begin
    if (!rstN)
      stackPtr <= '0;
    else if (ctrl.enter)
      stackPtr <= stackPtr + CNTW'(1);
    else if (ctrl.leave)
      stackPtr <= stackPtr - CNTW'(1);
  end

  // Current status: enable and level
  always_ff @(posedge clk) begin
    if (!rstN) begin
      status.ie  <= 1'b0;
      status.lvl <= LVL_NEVER;
    end else if (ctrl.enter) begin
      status.lvl <= lvlReg;
    end else if (ctrl.leave) begin
      status <= stackMem[popIdx];
    end else if (ctrl.wrStatus) begin
      status.ie  <= regWrData[STAT_IE_BIT];
      status.lvl <= regWrData[1:0];
    end
  end

  AST_STACK_BOUND: assert property (@(posedge clk) disable iff (!rstN)
    stackPtr <= CNTW'(DEPTH)); // R10
  AST_LEVEL3_NEVER: assert property (@(posedge clk) disable iff (!rstN)
    ctrl.capture |=> lvlReg != LVL_NEVER); // R3
  AST_ENTER_URGENT: assert property (@(posedge clk) disable iff (!rstN)
    ctrl.enter |=> (status.lvl < $past(status.lvl)) && (status.ie == $past(status.ie))); // R6
  AST_PUSH_DEPTH: assert property (@(posedge clk) disable iff (!rstN)
    ctrl.enter |=> stackPtr == $past(stackPtr) + CNTW'(1)); // R7

endmodule

// File: rtl/ilc_control.sv
module ilc_control
  import ilc_pkg::*;
(
  input  logic  clk,
  input  logic  rstN,
  input  logic  anyEligible,
  input  logic  stackFull,
  input  logic  stackEmpty,
  input  logic  intAck,
  input  logic  retStrobe,
  input  logic  wrStatusReq,
  output ctrl_t ctrl,
  output logic  intReq
);

  logic held;

  always_comb begin
    ctrl.capture  = !held && anyEligible && !stackFull;
    ctrl.enter    = held && intAck;
    ctrl.leave    = retStrobe && !stackEmpty && !ctrl.enter;
    ctrl.wrStatus = wrStatusReq && !ctrl.enter && !ctrl.leave;
  end

  always_ff @(posedge clk) begin
    if (!rstN)
      held <= 1'b0;
    else if (ctrl.enter)
      held <= 1'b0;
    else if (ctrl.capture)
      held <= 1'b1;
  end

  assign intReq = held;

  AST_ACK_DROPS: assert property (@(posedge clk) disable iff (!rstN)
    (intReq && intAck) |=> !intReq); // R5
  AST_NO_FULL_GRANT: assert property (@(posedge clk) disable iff (!rstN)
    (!intReq && stackFull) |=> !intReq); // R10
  AST_ONE_ACTION: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({ctrl.enter, ctrl.leave, ctrl.wrStatus})); // R11

endmodule

// File: rtl/irq_level_ctrl.sv
module irq_level_ctrl
  import ilc_pkg::*;
#(
  parameter int NUM_SRC = 16,
  parameter int DEPTH   = 4,
  parameter int DW      = 8,
  localparam int NUM_REGS = (NUM_SRC + DW/2 - 1) / (DW/2),
  localparam int AW       = $clog2(NUM_REGS + 1),
  localparam int VW       = $clog2(NUM_SRC)
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [NUM_SRC-1:0] irqReq,
  input  logic               regWrEn,
  input  logic [AW-1:0]      regAddr,
  input  logic [DW-1:0]      regWrData,
  input  logic               intAck,
  input  logic               retStrobe,
  output logic               intReq,
  output logic [VW-1:0]      vecIdx,
  output logic               pcSave,
  output logic [1:0]         statusLevel,
  output logic               statusIe
);

  ctrl_t   ctrl;
  status_t status;
  logic    anyEligible;
  logic    stackFull;
  logic    stackEmpty;
  logic    wrStatusReq;

  assign wrStatusReq = regWrEn && (regAddr == AW'(NUM_REGS));

  ilc_control u_control (
    .clk         (clk),
    .rstN        (rstN),
    .anyEligible (anyEligible),
    .stackFull   (stackFull),
    .stackEmpty  (stackEmpty),
    .intAck      (intAck),
    .retStrobe   (retStrobe),
    .wrStatusReq (wrStatusReq),
    .ctrl        (ctrl),
    .intReq      (intReq)
  );

  ilc_datapath #(
    .NUM_SRC (NUM_SRC),
    .DEPTH   (DEPTH),
    .DW      (DW),
    .AW      (AW),
    .VW      (VW)
  ) u_datapath (
    .clk         (clk),
    .rstN        (rstN),
    .ctrl        (ctrl),
    .irqReq      (irqReq),
    .regWrEn     (regWrEn),
    .regAddr     (regAddr),
    .regWrData   (regWrData),
    .anyEligible (anyEligible),
    .stackFull   (stackFull),
    .stackEmpty  (stackEmpty),
    .vecIdx      (vecIdx),
    .status      (status)
  );

  assign pcSave      = ctrl.enter;
  assign statusLevel = status.lvl;
  assign statusIe    = status.ie;

  AST_GRANT_HELD: assert property (@(posedge clk) disable iff (!rstN)
    (intReq && !intAck) |=> intReq && $stable(vecIdx)); // R5
  AST_GRANT_ENABLED: assert property (@(posedge clk) disable iff (!rstN)
    $rose(intReq) |-> $past(statusIe)); // R3
  AST_RET_EMPTY: assert property (@(posedge clk) disable iff (!rstN)
    (retStrobe && stackEmpty && !regWrEn && !(intReq && intAck))
      |=> $stable(statusLevel) && $stable(statusIe)); // R8

endmodule

// File: tb/irq_level_ctrl_test.sv
module irq_level_ctrl_test;

  localparam int NS = 16;

  logic          clk = 1'b0;
  logic          rstN;
  logic [NS-1:0] irqReq;
  logic          regWrEn;
  logic [2:0]    regAddr;
  logic [7:0]    regWrData;
  logic          intAck;
  logic          retStrobe;
  logic          intReq;
  logic [3:0]    vecIdx;
  logic          pcSave;
  logic [1:0]    statusLevel;
  logic          statusIe;

  always #5 clk = ~clk;

  irq_level_ctrl uut (
    .clk         (clk),
    .rstN        (rstN),
    .irqReq      (irqReq),
    .regWrEn     (regWrEn),
    .regAddr     (regAddr),
    .regWrData   (regWrData),
    .intAck      (intAck),
    .retStrobe   (retStrobe),
    .intReq      (intReq),
    .vecIdx      (vecIdx),
    .pcSave      (pcSave),
    .statusLevel (statusLevel),
    .statusIe    (statusIe)
  );

  int         testCnt = 0;
  int         failCnt = 0;
  bit         autoAck = 1'b1;
  logic [5:0] expQ [$];
  logic [5:0] monItem;

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    testCnt++;
    if (!ok) begin
      failCnt++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wrReg(input logic [2:0] a, input logic [7:0] d);
    regWrEn = 1'b1; regAddr = a; regWrData = d;
    @(negedge clk);
    regWrEn = 1'b0;
  endtask

  task automatic pulseRet();
    retStrobe = 1'b1;
    @(negedge clk);
    retStrobe = 1'b0;
  endtask

  task automatic expectAccept(input int vec, input int lvl);
    expQ.push_back({4'(vec), 2'(lvl)});
  endtask

  task automatic waitDrain();
    int guard = 0;
    while (expQ.size() != 0 && guard < 200) begin
      @(negedge clk);
      guard++;
    end
    check(expQ.size() == 0, "R3 expected grant never came", expQ.size(), 0);
    tick(1);
  endtask

  // Monitor: acknowledges grants and compares against the scoreboard
  initial begin
    forever begin
      @(negedge clk);
      if (autoAck && intReq) begin
        if (expQ.size() == 0) begin
          check(1'b0, "R3 unexpected grant", vecIdx, -1);
          intAck = 1'b1;
          @(negedge clk);
          intAck = 1'b0;
        end else begin
          monItem = expQ[0];
          check(vecIdx == monItem[5:2], "R4 granted vector", vecIdx, monItem[5:2]);
          intAck = 1'b1;
          @(negedge clk);
          intAck = 1'b0;
          check(statusLevel == monItem[1:0], "R6 level on entry", statusLevel, monItem[1:0]);
          void'(expQ.pop_front());
        end
      end
    end
  end

  // Watchdog
  initial begin
    repeat (100000) @(posedge clk);
    testCnt++;
    failCnt++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("[TB] %0d tests run, %0d failed", testCnt, failCnt);
    $finish;
  end

  initial begin
    rstN = 1'b0; irqReq = '0; regWrEn = 1'b0; regAddr = '0; regWrData = '0;
    intAck = 1'b0; retStrobe = 1'b0;
    tick(3);
    rstN = 1'b1;
    tick(1);

    // R1 reset state
    check(intReq == 1'b0, "R1 grant after reset", intReq, 0);
    check(statusLevel == 2'd3, "R1 level after reset", statusLevel, 3);
    check(statusIe == 1'b0, "R1 enable after reset", statusIe, 0);

    // R2 status write
    wrReg(3'd4, 8'h07);
    check(statusLevel == 2'd3 && statusIe == 1'b1, "R2 status write", {statusIe, statusLevel}, 7);

    // R1 default source levels are 3: nothing granted
    irqReq = '1;
    tick(5);
    check(intReq == 1'b0, "R1 default level 3 never granted", intReq, 0);
    irqReq = '0;

    // Program levels with interrupts disabled
    wrReg(3'd4, 8'h03);
    wrReg(3'd0, 8'h36); // src0=2 src1=1 src2=3 src3=0(acts as 1)
    wrReg(3'd1, 8'hFA); // src4=2 src5=2
    wrReg(3'd3, 8'h7F); // src15=1

    // R3 global enable off blocks
    irqReq[0] = 1'b1;
    tick(4);
    check(intReq == 1'b0, "R3 enable off blocks", intReq, 0);

    // Enable: source 0 at level 2 accepted
    expectAccept(0, 2);
    wrReg(3'd4, 8'h07);
    waitDrain();
    check(statusIe == 1'b1, "R6 enable kept on entry", statusIe, 1);

    // R7 nesting: level 1 preempts level 2
    expectAccept(1, 1);
    irqReq[1] = 1'b1;
    waitDrain();
    check(statusLevel == 2'd1, "R7 nested level", statusLevel, 1);

    // R3 equal-or-less urgent is blocked
    irqReq[4] = 1'b1;
    tick(4);
    check(intReq == 1'b0, "R3 level 2 under level 1 blocked", intReq, 0);

    irqReq[0] = 1'b0; irqReq[1] = 1'b0; irqReq[4] = 1'b0;
    tick(1);
    pulseRet();
    check(statusLevel == 2'd2, "R7 first return", statusLevel, 2);
    pulseRet();
    check(statusLevel == 2'd3 && statusIe, "R7 second return", {statusIe, statusLevel}, 7);
    pulseRet();
    check(statusLevel == 2'd3 && statusIe, "R8 return on empty stack", {statusIe, statusLevel}, 7);

    // R4 tie at level 2: lower index first
    expectAccept(4, 2);
    irqReq[4] = 1'b1; irqReq[5] = 1'b1;
    waitDrain();
    expectAccept(5, 2);
    irqReq[4] = 1'b0;
    pulseRet();
    waitDrain();
    irqReq[5] = 1'b0;
    pulseRet();
    check(statusLevel == 2'd3, "R7 back to idle level", statusLevel, 3);

    // R4 / R2 most urgent wins; field 00 acts as level 1
    expectAccept(3, 1);
    irqReq[0] = 1'b1; irqReq[3] = 1'b1; irqReq[15] = 1'b1;
    waitDrain();
    expectAccept(15, 1);
    irqReq[3] = 1'b0;
    pulseRet();
    waitDrain();
    expectAccept(0, 2);
    irqReq[15] = 1'b0;
    pulseRet();
    waitDrain();
    irqReq[0] = 1'b0;
    pulseRet();
    check(statusLevel == 2'd3, "R7 restored after sequence", statusLevel, 3);

    // R5 hold until acknowledge, R6 save strobe
    autoAck = 1'b0;
    irqReq[1] = 1'b1;
    tick(1);
    check(intReq == 1'b1, "R5 grant one edge after request", intReq, 1);
    check(vecIdx == 4'd1, "R5 vector on grant", vecIdx, 1);
    irqReq[3] = 1'b1;
    tick(3);
    check(intReq == 1'b1 && vecIdx == 4'd1, "R5 grant held", vecIdx, 1);
    check(statusLevel == 2'd3, "R5 level unchanged before ack", statusLevel, 3);
    intAck = 1'b1;
    #1;
    check(pcSave == 1'b1, "R6 save strobe in ack cycle", pcSave, 1);
    @(negedge clk);
    intAck = 1'b0;
    check(intReq == 1'b0, "R5 grant drops after ack", intReq, 0);
    check(statusLevel == 2'd1, "R6 level after manual ack", statusLevel, 1);
    check(pcSave == 1'b0, "R6 save strobe clears", pcSave, 0);
    irqReq[1] = 1'b0; irqReq[3] = 1'b0;
    pulseRet();
    autoAck = 1'b1;

    // R9 level 0 blocks everything
    wrReg(3'd4, 8'h04);
    check(statusLevel == 2'd0, "R9 level 0 written", statusLevel, 0);
    irqReq[1] = 1'b1;
    tick(4);
    check(intReq == 1'b0, "R9 level 0 blocks", intReq, 0);
    irqReq = '0;
    wrReg(3'd4, 8'h07);

    // R10 full stack blocks further grants
    for (int k = 0; k < 4; k++) begin
      expectAccept(1, 1);
      irqReq[1] = 1'b1;
      waitDrain();
      wrReg(3'd4, 8'h07);
    end
    tick(5);
    check(intReq == 1'b0, "R10 full stack blocks", intReq, 0);
    irqReq[1] = 1'b0;
    for (int k = 0; k < 4; k++) pulseRet();
    check(statusLevel == 2'd3 && statusIe, "R7 unwind full stack", {statusIe, statusLevel}, 7);
    pulseRet();
    check(statusLevel == 2'd3 && statusIe, "R8 return after unwind", {statusIe, statusLevel}, 7);

    // R11 precedence
    autoAck = 1'b0;
    irqReq[1] = 1'b1;
    tick(1);
    check(intReq == 1'b1, "R11 grant present", intReq, 1);
    intAck = 1'b1;
    regWrEn = 1'b1; regAddr = 3'd4; regWrData = 8'h03;
    @(negedge clk);
    intAck = 1'b0; regWrEn = 1'b0;
    check(statusLevel == 2'd1 && statusIe, "R11 ack beats status write", {statusIe, statusLevel}, 5);
    irqReq[1] = 1'b0;
    retStrobe = 1'b1;
    regWrEn = 1'b1; regAddr = 3'd4; regWrData = 8'h00;
    @(negedge clk);
    retStrobe = 1'b0; regWrEn = 1'b0;
    check(statusLevel == 2'd3 && statusIe, "R11 return beats status write", {statusIe, statusLevel}, 7);
    autoAck = 1'b1;
    tick(2);

    $display("[TB] %0d tests run, %0d failed", testCnt, failCnt);
    $finish;
  end

endmodule